// File: doc/BRIEF.md
# Register Rename Unit with Free List and Dual Map Tables

This block gives each decoded instruction of a single-issue out-of-order core fresh physical register names. Decoded requests wait in a small circular request queue. The oldest request reads a speculative map table through three ports: the first source, the second source and the current mapping of its destination. If the request writes a destination, the block hands it the physical register at the head of a circular free list. The speculative table then points that destination at the new register. Downstream stages receive the physical sources, the new destination and the displaced mapping, under a valid/ready handshake.

Retirement is reported through a commit port. It carries the destination, its new physical register and the displaced one. The commit port updates a separate committed map table and returns the displaced register to the tail of the free list. A flush throws away every queued request and any rename in the same cycle. The committed table, including a commit in that same cycle, is copied into the speculative table. The free list is then refilled, in ascending order, with every physical register that the committed table does not reference.

Architectural register 0 is hard-wired to physical register 0. It is never renamed, never allocated and never freed.

Top module: `rn_rename_top`

## Requirements
- R1: After reset, architectural register k (0 to 31) maps to physical register k, and the free list holds physical registers 32 to 63, handed out in ascending order; in_ready is 1 and out_valid is 0.
- R2: out_ps1 and out_ps2 give the speculative mapping of out_rs1 and out_rs2, including renames that fired in earlier cycles.
- R3: A request with in_has_rd=1 and a nonzero rd takes out_pd from the free-list head, and gets out_pd_old equal to the speculative mapping of rd before the rename; out_pd is never 0.
- R4: A request with in_has_rd=1 and rd=0 gets out_pd=0 and out_pd_old=0, and consumes no free register; any source field equal to 0 reads physical register 0.
- R5: A request with in_has_rd=0 gets out_pd=0 and out_pd_old=0 and can be renamed even when the free list is empty.
- R6: When the queue head needs a destination and the free list is empty, out_valid is 0 until a register is freed.
- R7: A commit (cm_valid=1, cm_rd nonzero) sets the committed mapping of cm_rd to cm_pd and appends cm_pd_old to the tail of the free list, behind any registers already there.
- R8: While flush is 1, in_ready and out_valid are 0, nothing is enqueued or renamed, and the queue is emptied. From the next cycle on, the speculative table equals the committed table, including a commit made in the flush cycle.
- R9: A flush refills the free list in ascending order with the physical registers that the committed table does not reference, so the next allocations come out lowest-number first.
- R10: The request queue holds 4 requests and serves them in arrival order; in_ready is 0 while it holds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard speculative state and rebuild it from the committed table |
| in_valid | input | 1 | Decoded request offered |
| in_ready | output | 1 | Request queue can take a request |
| in_rs1 | input | 5 | First source architectural register |
| in_rs2 | input | 5 | Second source architectural register |
| in_rd | input | 5 | Destination architectural register |
| in_has_rd | input | 1 | Request writes a destination |
| out_valid | output | 1 | Renamed request available |
| out_ready | input | 1 | Downstream accepts the renamed request |
| out_rs1 | output | 5 | First source architectural register of the head request |
| out_rs2 | output | 5 | Second source architectural register of the head request |
| out_rd | output | 5 | Destination architectural register of the head request |
| out_has_rd | output | 1 | Head request writes a destination |
| out_ps1 | output | 6 | Physical register of the first source |
| out_ps2 | output | 6 | Physical register of the second source |
| out_pd | output | 6 | Newly allocated physical destination, 0 if none |
| out_pd_old | output | 6 | Displaced physical mapping of the destination, 0 if none |
| cm_valid | input | 1 | An instruction with a destination retires |
| cm_rd | input | 5 | Retiring destination architectural register |
| cm_pd | input | 6 | Physical register now holding that destination |
| cm_pd_old | input | 6 | Physical register released by the retirement |

## Verification
A corrupted speculative entry shows up on out_ps1, out_ps2 or out_pd_old the first time a later request names that architectural register. That is usually within a few cycles under random traffic. A lost, duplicated or misordered free-list entry shows up on out_pd as soon as the free list wraps around to it. A miscounted free list also shows up as a stall on out_valid that comes too early or too late. A faulty flush rebuild shows up on the first allocation after the flush, because the expected value is the lowest unreferenced physical register. A faulty copy of the committed table shows up on the first source read after the flush.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned RN_ARCH_DEF  = 32;
  localparam int unsigned RN_PHYS_DEF  = 64;
  localparam int unsigned RN_QUEUE_DEF = 4;

  // number of physical registers that can be free at once
  function automatic int unsigned free_capacity(int unsigned arch_n, int unsigned phys_n);
    return phys_n - arch_n;
  endfunction

  // circular pointer advance for any depth
  function automatic int unsigned wrap_inc(int unsigned ptr, int unsigned depth);
    return (ptr + 1 == depth) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/rn_req_queue.sv
module rn_req_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int unsigned PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    slot [DEPTH];
  logic [PTRW-1:0] rd_ptr, wr_ptr;
  logic [CNTW-1:0] cnt;

  assign full  = (cnt == CNTW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) begin
        slot[wr_ptr] <= din;
        wr_ptr <= PTRW'(rn_pkg::wrap_inc(32'(wr_ptr), DEPTH));
      end
      if (pop) rd_ptr <= PTRW'(rn_pkg::wrap_inc(32'(rd_ptr), DEPTH));
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (!push && pop) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned ARCH_REGS = 32,
  parameter int unsigned AW        = 5,
  parameter int unsigned PW        = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           rd_a1,
  input  logic [AW-1:0]           rd_a2,
  input  logic [AW-1:0]           rd_a3,
  output logic [PW-1:0]           rd_p1,
  output logic [PW-1:0]           rd_p2,
  output logic [PW-1:0]           rd_p3,
  input  logic                    sp_we,
  input  logic [AW-1:0]           sp_wa,
  input  logic [PW-1:0]           sp_wd,
  input  logic                    cm_we,
  input  logic [AW-1:0]           cm_wa,
  input  logic [PW-1:0]           cm_wd,
  input  logic                    recover,
  output logic [ARCH_REGS*PW-1:0] com_next_flat
);
  logic [PW-1:0] spec_q [ARCH_REGS];
  logic [PW-1:0] com_q  [ARCH_REGS];
  logic [PW-1:0] com_d  [ARCH_REGS];

  assign rd_p1 = spec_q[rd_a1];
  assign rd_p2 = spec_q[rd_a2];
  assign rd_p3 = spec_q[rd_a3];

  always_comb begin
    com_d = com_q;
    if (cm_we && cm_wa != '0) com_d[cm_wa] = cm_wd;
  end

  for (genvar g = 0; g < ARCH_REGS; g++) begin : g_flat
    assign com_next_flat[g*PW +: PW] = com_d[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) begin
        spec_q[i] <= PW'(i);
        com_q[i]  <= PW'(i);
      end
    end else begin
      com_q <= com_d;
      if (recover) spec_q <= com_d;
      else if (sp_we && sp_wa != '0) spec_q[sp_wa] <= sp_wd;
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned ARCH_REGS = 32,
  parameter int unsigned PHYS_REGS = 64,
  parameter int unsigned PW        = 6,
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned CW        = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pop,
  input  logic                    push,
  input  logic [PW-1:0]           push_reg,
  input  logic                    rebuild,
  input  logic [ARCH_REGS*PW-1:0] ref_flat,
  output logic [PW-1:0]           head_reg,
  output logic                    empty,
  output logic [CW-1:0]           count
);
  localparam int unsigned FW = $clog2(DEPTH);

  logic [PW-1:0]        ring [DEPTH];
  logic [FW-1:0]        hd, tl;
  logic [PHYS_REGS-1:0] used;
  logic [PW-1:0]        rb_list [DEPTH];
  logic [CW-1:0]        rb_cnt;

  assign head_reg = ring[hd];
  assign empty    = (count == '0);

  // ascending list of physical registers the committed table leaves unreferenced
  always_comb begin
    used = '0;
    for (int a = 0; a < ARCH_REGS; a++) used[ref_flat[a*PW +: PW]] = 1'b1;
    rb_list = '{default: '0};
    rb_cnt  = '0;
    for (int p = 0; p < PHYS_REGS; p++) begin
      if (!used[p] && rb_cnt < CW'(DEPTH)) begin
        rb_list[rb_cnt[FW-1:0]] = PW'(p);
        rb_cnt = rb_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ring[i] <= PW'(ARCH_REGS + i);
      hd    <= '0;
      tl    <= '0;
      count <= CW'(DEPTH);
    end else if (rebuild) begin
      ring  <= rb_list;
      hd    <= '0;
      tl    <= (rb_cnt == CW'(DEPTH)) ? '0 : rb_cnt[FW-1:0];
      count <= rb_cnt;
    end else begin
      if (pop) hd <= FW'(rn_pkg::wrap_inc(32'(hd), DEPTH));
      if (push) begin
        ring[tl] <= push_reg;
        tl <= FW'(rn_pkg::wrap_inc(32'(tl), DEPTH));
      end
      if (push && !pop)      count <= count + 1'b1;
      else if (!push && pop) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/rn_rename_top.sv
module rn_rename_top #(
  parameter int unsigned ARCH_REGS   = rn_pkg::RN_ARCH_DEF,
  parameter int unsigned PHYS_REGS   = rn_pkg::RN_PHYS_DEF,
  parameter int unsigned QUEUE_DEPTH = rn_pkg::RN_QUEUE_DEF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [$clog2(ARCH_REGS)-1:0] in_rs1,
  input  logic [$clog2(ARCH_REGS)-1:0] in_rs2,
  input  logic [$clog2(ARCH_REGS)-1:0] in_rd,
  input  logic                         in_has_rd,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [$clog2(ARCH_REGS)-1:0] out_rs1,
  output logic [$clog2(ARCH_REGS)-1:0] out_rs2,
  output logic [$clog2(ARCH_REGS)-1:0] out_rd,
  output logic                         out_has_rd,
  output logic [$clog2(PHYS_REGS)-1:0] out_ps1,
  output logic [$clog2(PHYS_REGS)-1:0] out_ps2,
  output logic [$clog2(PHYS_REGS)-1:0] out_pd,
  output logic [$clog2(PHYS_REGS)-1:0] out_pd_old,
  input  logic                         cm_valid,
  input  logic [$clog2(ARCH_REGS)-1:0] cm_rd,
  input  logic [$clog2(PHYS_REGS)-1:0] cm_pd,
  input  logic [$clog2(PHYS_REGS)-1:0] cm_pd_old
);
  localparam int unsigned AW       = $clog2(ARCH_REGS);
  localparam int unsigned PW       = $clog2(PHYS_REGS);
  localparam int unsigned FL_DEPTH = rn_pkg::free_capacity(ARCH_REGS, PHYS_REGS);
  localparam int unsigned FL_CW    = $clog2(FL_DEPTH + 1);
  localparam int unsigned QW       = 3 * AW + 1;

  logic [QW-1:0]           q_dout;
  logic                    q_full, q_empty;
  logic                    fl_empty;
  logic [FL_CW-1:0]        fl_count;
  logic [PW-1:0]           fl_head;
  logic [PW-1:0]           map_p3;
  logic [ARCH_REGS*PW-1:0] com_next_flat;

  // named internal events
  logic head_needs_reg, rename_fire, alloc_take, free_give, commit_write, recover_now;

  assign {out_has_rd, out_rd, out_rs2, out_rs1} = q_dout;

  assign recover_now    = flush;
  assign head_needs_reg = out_has_rd && (out_rd != '0);
  assign in_ready       = !q_full && !recover_now;
  assign out_valid      = !q_empty && !recover_now && (!head_needs_reg || !fl_empty);
  assign rename_fire    = out_valid && out_ready;
  assign alloc_take     = rename_fire && head_needs_reg;
  assign commit_write   = cm_valid && (cm_rd != '0);
  assign free_give      = commit_write && !recover_now;

  assign out_pd     = head_needs_reg ? fl_head : '0;
  assign out_pd_old = head_needs_reg ? map_p3  : '0;

  rn_req_queue #(.DEPTH(QUEUE_DEPTH), .W(QW)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (recover_now),
    .push  (in_valid && in_ready),
    .din   ({in_has_rd, in_rd, in_rs2, in_rs1}),
    .pop   (rename_fire),
    .dout  (q_dout),
    .full  (q_full),
    .empty (q_empty)
  );

  rn_map_table #(.ARCH_REGS(ARCH_REGS), .AW(AW), .PW(PW)) u_map (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_a1         (out_rs1),
    .rd_a2         (out_rs2),
    .rd_a3         (out_rd),
    .rd_p1         (out_ps1),
    .rd_p2         (out_ps2),
    .rd_p3         (map_p3),
    .sp_we         (alloc_take),
    .sp_wa         (out_rd),
    .sp_wd         (fl_head),
    .cm_we         (commit_write),
    .cm_wa         (cm_rd),
    .cm_wd         (cm_pd),
    .recover       (recover_now),
    .com_next_flat (com_next_flat)
  );

  rn_free_list #(
    .ARCH_REGS (ARCH_REGS),
    .PHYS_REGS (PHYS_REGS),
    .PW        (PW),
    .DEPTH     (FL_DEPTH),
    .CW        (FL_CW)
  ) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (alloc_take),
    .push     (free_give),
    .push_reg (cm_pd_old),
    .rebuild  (recover_now),
    .ref_flat (com_next_flat),
    .head_reg (fl_head),
    .empty    (fl_empty),
    .count    (fl_count)
  );
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
  parameter int unsigned AW     = 5,
  parameter int unsigned PW     = 6,
  parameter int unsigned CW     = 6,
  parameter int unsigned FL_CAP = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          in_ready,
  input logic          out_valid,
  input logic [AW-1:0] out_rs1,
  input logic [AW-1:0] out_rs2,
  input logic [AW-1:0] out_rd,
  input logic          out_has_rd,
  input logic [PW-1:0] out_ps1,
  input logic [PW-1:0] out_ps2,
  input logic [PW-1:0] out_pd,
  input logic [PW-1:0] out_pd_old,
  input logic          q_full,
  input logic          fl_empty,
  input logic [CW-1:0] fl_count,
  input logic          alloc_take,
  input logic          free_give
);
  assert_zero_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rs1 == '0) |-> (out_ps1 == '0));

  assert_zero_src2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rs2 == '0) |-> (out_ps2 == '0));

  assert_zero_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_has_rd && out_rd == '0) |-> (out_pd == '0 && out_pd_old == '0));

  assert_new_dest_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_has_rd && out_rd != '0) |-> (out_pd != '0));

  assert_alloc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_take && !free_give && !flush) |=> (fl_count == $past(fl_count) - 1'b1));

  assert_stall_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_empty && out_has_rd && out_rd != '0) |-> !out_valid);

  assert_free_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_count <= CW'(FL_CAP));

  assert_flush_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!out_valid && !in_ready));

  assert_rebuild_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fl_count == CW'(FL_CAP) && !out_valid));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !in_ready);
endmodule

bind rn_rename_top rn_rename_chk #(
  .AW(AW), .PW(PW), .CW(FL_CW), .FL_CAP(FL_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_rs1    (out_rs1),
  .out_rs2    (out_rs2),
  .out_rd     (out_rd),
  .out_has_rd (out_has_rd),
  .out_ps1    (out_ps1),
  .out_ps2    (out_ps2),
  .out_pd     (out_pd),
  .out_pd_old (out_pd_old),
  .q_full     (q_full),
  .fl_empty   (fl_empty),
  .fl_count   (fl_count),
  .alloc_take (alloc_take),
  .free_give  (free_give)
);

// File: tb/sim_rn_rename_top.sv
`timescale 1ns/1ps
module sim_rn_rename_top;
  localparam int AR  = 32;
  localparam int PR  = 64;
  localparam int QD  = 4;
  localparam int FLC = PR - AR;

  logic       clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic       in_valid = 1'b0, in_has_rd = 1'b0, out_ready = 1'b0, cm_valid = 1'b0;
  logic [4:0] in_rs1 = '0, in_rs2 = '0, in_rd = '0, cm_rd = '0;
  logic [5:0] cm_pd = '0, cm_pd_old = '0;
  wire        in_ready, out_valid, out_has_rd;
  wire  [4:0] out_rs1, out_rs2, out_rd;
  wire  [5:0] out_ps1, out_ps2, out_pd, out_pd_old;

  always #4 clk = ~clk;

  rn_rename_top u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .in_rd(in_rd), .in_has_rd(in_has_rd),
    .out_valid(out_valid), .out_ready(out_ready), .out_rs1(out_rs1), .out_rs2(out_rs2),
    .out_rd(out_rd), .out_has_rd(out_has_rd), .out_ps1(out_ps1), .out_ps2(out_ps2),
    .out_pd(out_pd), .out_pd_old(out_pd_old),
    .cm_valid(cm_valid), .cm_rd(cm_rd), .cm_pd(cm_pd), .cm_pd_old(cm_pd_old)
  );

  typedef struct { int rs1; int rs2; int rd; bit has; } req_t;
  typedef struct { int rd; int pd; int old; } inf_t;

  int    spec_m [AR];
  int    com_m  [AR];
  int    fl_m   [$];
  string fl_tag [$];
  req_t  mq     [$];
  inf_t  infl   [$];
  int    n_tests = 0, n_fail = 0;
  bit    since_flush = 1'b0, done = 1'b0;

  function automatic bit needs_m(req_t r);
    return r.has && r.rd != 0;
  endfunction

  // free registers are those no committed mapping uses, lowest first
  function automatic void refill_m(string tag);
    bit used [PR];
    fl_m.delete();
    fl_tag.delete();
    for (int p = 0; p < PR; p++) used[p] = 1'b0;
    for (int a = 0; a < AR; a++) used[com_m[a]] = 1'b1;
    for (int p = 0; p < PR; p++)
      if (!used[p] && fl_m.size() < FLC) begin
        fl_m.push_back(p);
        fl_tag.push_back(tag);
      end
  endfunction

  function automatic void init_m();
    for (int a = 0; a < AR; a++) begin
      spec_m[a] = a;
      com_m[a]  = a;
    end
    refill_m("R1");
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called just after a falling edge with inputs set
  task automatic step();
    req_t h;
    bit   e_ready, e_valid, need;
    int   e_old;
    #1;
    e_ready = (mq.size() < QD) && !flush;
    check(flush ? "R8 in_ready during flush" : "R10 in_ready", int'(in_ready), int'(e_ready));
    e_valid = 1'b0;
    need    = 1'b0;
    e_old   = 0;
    h       = '{0, 0, 0, 1'b0};
    if (mq.size() > 0) begin
      h       = mq[0];
      need    = needs_m(h);
      e_valid = !flush && (!need || fl_m.size() > 0);
    end
    check(flush ? "R8 out_valid during flush" : "R6 out_valid", int'(out_valid), int'(e_valid));
    if (e_valid && out_valid) begin
      check("R10 head order rs1", int'(out_rs1), h.rs1);
      check("R10 head order rd", int'(out_rd), h.rd);
      check(since_flush ? "R8 ps1 from committed map" : "R2 ps1", int'(out_ps1), spec_m[h.rs1]);
      check(since_flush ? "R8 ps2 from committed map" : "R2 ps2", int'(out_ps2), spec_m[h.rs2]);
      if (need) begin
        e_old = spec_m[h.rd];
        check({fl_tag[0], " pd from free list"}, int'(out_pd), fl_m[0]);
        check("R3 pd_old", int'(out_pd_old), e_old);
      end else begin
        check(h.has ? "R4 pd for x0" : "R5 pd without rd", int'(out_pd), 0);
        check(h.has ? "R4 pd_old for x0" : "R5 pd_old without rd", int'(out_pd_old), 0);
      end
    end
    @(posedge clk);
    if (flush) begin
      if (cm_valid) begin
        if (infl[0].rd != 0) com_m[infl[0].rd] = infl[0].pd;
        void'(infl.pop_front());
      end
      for (int a = 0; a < AR; a++) spec_m[a] = com_m[a];
      mq.delete();
      infl.delete();
      refill_m("R9");
      since_flush = 1'b1;
    end else begin
      if (e_valid && out_ready) begin
        void'(mq.pop_front());
        if (need) begin
          spec_m[h.rd] = fl_m[0];
          infl.push_back('{h.rd, fl_m[0], e_old});
          void'(fl_m.pop_front());
          void'(fl_tag.pop_front());
          since_flush = 1'b0;
        end
      end
      if (cm_valid) begin
        com_m[infl[0].rd] = infl[0].pd;
        fl_m.push_back(infl[0].old);
        fl_tag.push_back("R7");
        void'(infl.pop_front());
      end
      if (in_valid && e_ready) mq.push_back('{int'(in_rs1), int'(in_rs2), int'(in_rd), bit'(in_has_rd)});
    end
    @(negedge clk);
  endtask

  task automatic drive_commit(int pct);
    if (infl.size() > 0 && int'($urandom % 100) < pct) begin
      cm_valid  = 1'b1;
      cm_rd     = 5'(infl[0].rd);
      cm_pd     = 6'(infl[0].pd);
      cm_pd_old = 6'(infl[0].old);
    end else begin
      cm_valid = 1'b0;
    end
  endtask

  task automatic drive_rand(int pv, int pr, int pc, int pf);
    in_valid  = int'($urandom % 100) < pv;
    in_rs1    = 5'($urandom % 32);
    in_rs2    = 5'($urandom % 32);
    in_rd     = 5'($urandom % 32);
    in_has_rd = int'($urandom % 100) < 80;
    out_ready = int'($urandom % 100) < pr;
    drive_commit(pc);
    flush     = int'($urandom % 1000) < pf;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog on all requirements actual=%0d expected=%0d", 200000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    init_m();
    #1;
    check("R1 in_ready after reset", int'(in_ready), 1);
    check("R1 out_valid after reset", int'(out_valid), 0);

    // first rename after reset
    in_valid = 1'b1; in_rs1 = 5'd7; in_rs2 = 5'd31; in_rd = 5'd9; in_has_rd = 1'b1;
    out_ready = 1'b0;
    step();
    in_valid = 1'b0;
    #1;
    check("R1 identity ps1", int'(out_ps1), 7);
    check("R1 identity ps2", int'(out_ps2), 31);
    check("R1 first pd", int'(out_pd), 32);
    check("R1 identity pd_old", int'(out_pd_old), 9);
    out_ready = 1'b1;
    step();

    // dependent request reads the new mapping
    in_valid = 1'b1; in_rs1 = 5'd9; in_rs2 = 5'd0; in_rd = 5'd9; in_has_rd = 1'b1;
    step();
    in_valid = 1'b0;
    step();
    step();

    // fill the request queue with the output blocked
    out_ready = 1'b0;
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b1; in_rs1 = 5'($urandom % 32); in_rs2 = 5'($urandom % 32);
      in_rd = 5'($urandom % 32); in_has_rd = 1'($urandom % 2);
      step();
    end
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (5) step();

    // exhaust the free list with no retirement
    for (int i = 0; i < 40; i++) begin
      in_valid = 1'b1; in_has_rd = 1'b1; in_rd = 5'(1 + $urandom % 31);
      in_rs1 = 5'($urandom % 32); in_rs2 = 5'($urandom % 32);
      step();
    end
    in_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      drive_commit(100);
      step();
    end
    cm_valid = 1'b0;

    // flush with a commit and a renamable head in the same cycle
    in_valid = 1'b1; in_has_rd = 1'b1; in_rd = 5'd3;
    step();
    drive_commit(100);
    flush = 1'b1; out_ready = 1'b1;
    step();
    flush = 1'b0; cm_valid = 1'b0;
    step();
    in_valid = 1'b0;
    repeat (3) step();

    for (int i = 0; i < 4000; i++) begin
      drive_rand(70, 80, 50, 15);
      step();
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule